// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table from memory. The address splits into a 10-bit index into the root table, a 10-bit index into a second-level (leaf) table, and a 12-bit byte offset within a 4 KB page. Every table holds 1024 four-byte entries, so one table fills exactly one page. The physical frame of the root table comes from a directory base input. Software reloads that input when it switches address spaces.

A request carries a virtual address and an access kind. The walker reads the root entry and then the leaf entry over a simple one-word memory port. It checks the present bit at each level and checks the permission bits in the leaf. It then returns either a physical address or a 2-bit fault cause. On a successful walk it sets the referenced bit in the leaf entry, and on a write it also sets the modified bit. The updated entry is stored back only when its value changes. Only one walk is in flight at a time.

Top module: `pt_walker`

## Requirements
- R1: During and after reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_req` is 0.
- R2: The first read of a walk is at `{base[31:12], va[31:22], 2'b00}`. `base` is the value of `dir_base` sampled in the cycle the request is accepted. Later changes to `dir_base` do not affect that walk.
- R3: The second read is at `{root_entry[31:12], va[21:12], 2'b00}`.
- R4: Entry format: bit 0 present, bit 1 read enable, bit 2 write enable, bit 3 execute enable, bit 4 referenced, bit 5 modified, bit 6 cache disable, bits 31:12 frame number. A root entry with bit 0 clear ends the walk with fault code 01. No leaf read and no store take place.
- R5: A leaf entry with bit 0 clear ends the walk with fault code 10, and no store takes place.
- R6: Access codes are 00 read (needs bit 1), 01 write (needs bit 2), 10 execute (needs bit 3) and 11 always refused. A refused access gives fault code 11, and no store takes place.
- R7: On success the fault code is 00 and `rsp_pa` = `{leaf[31:12], va[11:0]}`. On any fault `rsp_pa` is 0.
- R8: On success the leaf entry gets bit 4 set, and a write access also sets bit 5. The entry is written back to the leaf address only if that changes its value, so a walk makes at most one store.
- R9: `rsp_nocache` equals leaf bit 6 on success and is 0 on any fault.
- R10: `req_ready` is low from the accepting edge until the cycle after the response. `rsp_valid` is a one-cycle pulse.
- R11: `mem_req` stays high with a stable address and write flag until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_base | input | 32 | Root table base; bits 31:12 are used |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_va | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind |
| rsp_valid | output | 1 | Response pulse |
| rsp_pa | output | 32 | Physical address |
| rsp_fault | output | 2 | Fault cause |
| rsp_nocache | output | 1 | Cache-disable flag of the leaf |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a store |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, valid with ack |
| mem_ack | input | 1 | Memory access done |

## Verification
The permission decision and the status-bit update are settled in the same cycle, when the leaf entry arrives. A wrong design could therefore store referenced or modified bits for an access it refuses. The bench provokes this with writes and execute accesses to leaf entries whose enable bit is clear and whose referenced bit is clear. The random walks do the same with random entries. Each walk is judged by counting stores and comparing the leaf word afterwards with the value the bench model predicts.

// File: rtl/ptw_pkg.sv
// Shared constants and types for the page table walker.
// Assumes entries are as wide as addresses, with flags in the low bits.
package ptw_pkg;
    localparam int E_PRESENT = 0;
    localparam int E_RD      = 1;
    localparam int E_WR      = 2;
    localparam int E_EX      = 3;
    localparam int E_REF     = 4;
    localparam int E_MOD     = 5;
    localparam int E_NC      = 6;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_EXEC  = 2'b10,
        ACC_NONE  = 2'b11
    } acc_t;

    typedef enum logic [1:0] {
        FLT_OK   = 2'b00,
        FLT_ROOT = 2'b01,
        FLT_LEAF = 2'b10,
        FLT_PERM = 2'b11
    } fault_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROOT,
        ST_LEAF,
        ST_UPD,
        ST_RESP
    } walk_state_t;
endpackage

// File: rtl/ptw_addr_gen.sv
// Builds the byte address of the entry fetched at each level.
// Assumes VA_W == OFF_W + 2*IDX_W and that OFF_W > IDX_W (entry byte bits).
module ptw_addr_gen #(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12,
    parameter int IDX_W = 10
) (
    input  logic [VA_W-OFF_W-1:0] root_frame,
    input  logic [VA_W-OFF_W-1:0] leaf_frame,
    input  logic [VA_W-1:0]       va,
    input  logic                  sel_leaf,
    output logic [VA_W-1:0]       addr
);
    localparam int PPN_W  = VA_W - OFF_W;
    localparam int BYTE_W = OFF_W - IDX_W;

    logic [IDX_W-1:0] root_idx;
    logic [IDX_W-1:0] leaf_idx;

    // Pick the index fields out of the virtual address.
    always_comb begin
        root_idx = va[VA_W-1 -: IDX_W];
        leaf_idx = va[OFF_W +: IDX_W];
    end

    generate
        if (BYTE_W > 0) begin : g_pad
            // Frame, index and zero byte bits for the selected level.
            always_comb begin
                if (sel_leaf)
                    addr = {leaf_frame, leaf_idx, {BYTE_W{1'b0}}};
                else
                    addr = {root_frame, root_idx, {BYTE_W{1'b0}}};
            end
        end else begin : g_nopad
            // Entries are single bytes: no padding bits.
            always_comb begin
                if (sel_leaf)
                    addr = {leaf_frame, leaf_idx};
                else
                    addr = {root_frame, root_idx};
            end
        end
    endgenerate

    logic unused_w;
    assign unused_w = ^PPN_W;
endmodule

// File: rtl/ptw_leaf_check.sv
// Judges a fetched leaf entry against the access kind and forms the
// status-updated entry. Purely combinational; assumes flag positions
// from ptw_pkg.
module ptw_leaf_check #(
    parameter int E_W = 32
) (
    input  logic [E_W-1:0] entry,
    input  logic [1:0]     acc,
    output logic [1:0]     fault,
    output logic [E_W-1:0] upd_entry,
    output logic           changed
);
    import ptw_pkg::*;

    logic allowed;

    // Select the enable bit that the access kind needs.
    always_comb begin
        case (acc_t'(acc))
            ACC_READ:  allowed = entry[E_RD];
            ACC_WRITE: allowed = entry[E_WR];
            ACC_EXEC:  allowed = entry[E_EX];
            default:   allowed = 1'b0;
        endcase
    end

    // Fault cause, new status bits and whether a store is needed.
    always_comb begin
        upd_entry = entry;
        if (!entry[E_PRESENT]) begin
            fault = FLT_LEAF;
        end else if (!allowed) begin
            fault = FLT_PERM;
        end else begin
            fault = FLT_OK;
            upd_entry[E_REF] = 1'b1;
            if (acc_t'(acc) == ACC_WRITE)
                upd_entry[E_MOD] = 1'b1;
        end
        changed = (upd_entry != entry);
    end
endmodule

// File: rtl/pt_walker.sv
// Two-level page table walker. Accepts one request at a time, reads the
// root and leaf entries, checks them, writes back status bits only when
// they change and pulses a response. Assumes a memory port that holds
// read data valid in the cycle mem_ack is high.
module pt_walker #(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12,
    parameter int IDX_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [VA_W-1:0] dir_base,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_va,
    input  logic [1:0]      req_acc,
    output logic            rsp_valid,
    output logic [VA_W-1:0] rsp_pa,
    output logic [1:0]      rsp_fault,
    output logic            rsp_nocache,
    output logic            mem_req,
    output logic            mem_we,
    output logic [VA_W-1:0] mem_addr,
    output logic [VA_W-1:0] mem_wdata,
    input  logic [VA_W-1:0] mem_rdata,
    input  logic            mem_ack
);
    import ptw_pkg::*;

    localparam int PPN_W = VA_W - OFF_W;

    walk_state_t      state;
    logic [VA_W-1:0]  va_q;
    logic [1:0]       acc_q;
    logic [PPN_W-1:0] base_q;
    logic [PPN_W-1:0] root_q;
    logic [VA_W-1:0]  upd_q;
    logic [VA_W-1:0]  pa_q;
    logic [1:0]       fault_q;
    logic             nc_q;

    logic [1:0]       chk_fault;
    logic [VA_W-1:0]  chk_upd;
    logic             chk_changed;

    ptw_addr_gen #(.VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_addr (
        .root_frame (base_q),
        .leaf_frame (root_q),
        .va         (va_q),
        .sel_leaf   (state != ST_ROOT),
        .addr       (mem_addr)
    );

    ptw_leaf_check #(.E_W(VA_W)) u_chk (
        .entry     (mem_rdata),
        .acc       (acc_q),
        .fault     (chk_fault),
        .upd_entry (chk_upd),
        .changed   (chk_changed)
    );

    // Port outputs decoded from the walk state.
    always_comb begin
        req_ready   = (state == ST_IDLE);
        mem_req     = (state == ST_ROOT) || (state == ST_LEAF) || (state == ST_UPD);
        mem_we      = (state == ST_UPD);
        mem_wdata   = upd_q;
        rsp_valid   = (state == ST_RESP);
        rsp_pa      = pa_q;
        rsp_fault   = fault_q;
        rsp_nocache = nc_q;
    end

    // Walk sequencer: accept, fetch root, fetch leaf, store, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            va_q    <= '0;
            acc_q   <= '0;
            base_q  <= '0;
            root_q  <= '0;
            upd_q   <= '0;
            pa_q    <= '0;
            fault_q <= FLT_OK;
            nc_q    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q   <= req_va;
                        acc_q  <= req_acc;
                        base_q <= dir_base[VA_W-1:OFF_W];
                        state  <= ST_ROOT;
                    end
                end
                ST_ROOT: begin
                    if (mem_ack) begin
                        if (!mem_rdata[E_PRESENT]) begin
                            fault_q <= FLT_ROOT;
                            pa_q    <= '0;
                            nc_q    <= 1'b0;
                            state   <= ST_RESP;
                        end else begin
                            root_q <= mem_rdata[VA_W-1:OFF_W];
                            state  <= ST_LEAF;
                        end
                    end
                end
                ST_LEAF: begin
                    if (mem_ack) begin
                        fault_q <= chk_fault;
                        upd_q   <= chk_upd;
                        if (chk_fault == FLT_OK) begin
                            pa_q  <= {mem_rdata[VA_W-1:OFF_W], va_q[OFF_W-1:0]};
                            nc_q  <= mem_rdata[E_NC];
                            state <= chk_changed ? ST_UPD : ST_RESP;
                        end else begin
                            pa_q  <= '0;
                            nc_q  <= 1'b0;
                            state <= ST_RESP;
                        end
                    end
                end
                ST_UPD: begin
                    if (mem_ack)
                        state <= ST_RESP;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R10: response lasts one cycle and the walker is idle right after.
    a_r10_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R10: an accepted request makes the walker busy.
    a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R11: an unacknowledged access holds its address and direction.
    a_r11_hold_access: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R8: every store carries the referenced bit.
    a_r8_store_has_ref: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[E_REF]);

    // R6: a refused or absent leaf never leads to a store.
    a_r6_no_store_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LEAF && mem_ack && chk_fault != FLT_OK) |=> !mem_we);

    // R7: a fault response carries a zero address.
    a_r7_fault_zero_pa: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != FLT_OK) |-> (rsp_pa == '0));

    // R9: a fault response never flags cache disable.
    a_r9_fault_no_nc: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != FLT_OK) |-> !rsp_nocache);
endmodule

// File: tb/sim_pt_walker.sv
// Bench for pt_walker: a one-cycle-latency memory model, directed corner
// cases, then seeded random walks checked against a bench reference.
module sim_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] dir_base = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic [1:0]  req_acc = '0;
    logic        rsp_valid;
    logic [31:0] rsp_pa;
    logic [1:0]  rsp_fault;
    logic        rsp_nocache;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        mem_ack;

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    pt_walker u0 (
        .clk(clk), .rst_n(rst_n), .dir_base(dir_base),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .req_acc(req_acc),
        .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
        .rsp_fault(rsp_fault), .rsp_nocache(rsp_nocache),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    // Memory: frames 0 and 2 hold root tables, frames 1 and 3 leaf tables.
    logic [31:0] mem [0:4095];
    int          n_rd = 0;
    int          n_st = 0;
    logic [31:0] rd_log [0:1];

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            mem_rdata <= '0;
        end else begin
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack) begin
                mem_ack <= 1'b1;
                mem_rdata <= mem[mem_addr[13:2]];
                if (mem_we) begin
                    mem[mem_addr[13:2]] = mem_wdata;
                    n_st = n_st + 1;
                end else begin
                    rd_log[n_rd % 2] = mem_addr;
                    n_rd = n_rd + 1;
                end
            end
        end
    end

    // Global watchdog: counts as a failed check and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_checks = n_checks + 1;
            n_errors = n_errors + 1;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks = n_checks + 1;
        if (!ok) begin
            n_errors = n_errors + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Bench reference of one walk, computed from the requirements.
    task automatic model(input logic [31:0] va, input logic [1:0] acc, input logic [31:0] base,
                         output logic [1:0] f, output logic [31:0] pa, output logic nc,
                         output int nrd, output logic [31:0] raddr, output logic [31:0] laddr,
                         output logic [31:0] oldleaf, output logic [31:0] newleaf);
        logic [31:0] re;
        logic        perm;
        raddr = {base[31:12], va[31:22], 2'b00};
        re = mem[raddr[13:2]];
        pa = '0; nc = 1'b0; laddr = '0; oldleaf = '0; newleaf = '0;
        if (!re[0]) begin
            f = 2'b01; nrd = 1;
            return;
        end
        nrd = 2;
        laddr = {re[31:12], va[21:12], 2'b00};
        oldleaf = mem[laddr[13:2]];
        newleaf = oldleaf;
        case (acc)
            2'b00: perm = oldleaf[1];
            2'b01: perm = oldleaf[2];
            2'b10: perm = oldleaf[3];
            default: perm = 1'b0;
        endcase
        if (!oldleaf[0]) f = 2'b10;
        else if (!perm) f = 2'b11;
        else begin
            f = 2'b00;
            pa = {oldleaf[31:12], va[11:0]};
            nc = oldleaf[6];
            newleaf = oldleaf | 32'h10 | ((acc == 2'b01) ? 32'h20 : 32'h0);
        end
    endtask

    task automatic do_walk(input logic [31:0] va, input logic [1:0] acc, input logic [31:0] base,
                           input logic mid_sw, input string tag);
        logic [1:0]  ef;
        logic [31:0] epa, eraddr, eladdr, eold, enew;
        logic        enc;
        int          enrd, rd0, st0, cyc;
        model(va, acc, base, ef, epa, enc, enrd, eraddr, eladdr, eold, enew);
        rd0 = n_rd;
        st0 = n_st;
        @(negedge clk);
        dir_base = base; req_va = va; req_acc = acc; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, {tag, " R10 busy after accept"}, {31'b0, req_ready}, 32'h0);
        if (mid_sw) dir_base = base ^ 32'h0000_2000;
        cyc = 0;
        while (!rsp_valid && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        chk(rsp_valid == 1'b1, {tag, " R10 response arrives"}, {31'b0, rsp_valid}, 32'h1);
        chk(rsp_fault == ef, {tag, " R4 R5 R6 fault code"}, {30'b0, rsp_fault}, {30'b0, ef});
        chk(rsp_pa == epa, {tag, " R7 physical address"}, rsp_pa, epa);
        chk(rsp_nocache == enc, {tag, " R9 cache disable"}, {31'b0, rsp_nocache}, {31'b0, enc});
        chk(n_rd - rd0 == enrd, {tag, " R4 read count"}, n_rd - rd0, enrd);
        chk(rd_log[rd0 % 2] == eraddr, {tag, " R2 root address"}, rd_log[rd0 % 2], eraddr);
        if (enrd == 2)
            chk(rd_log[(rd0 + 1) % 2] == eladdr, {tag, " R3 leaf address"}, rd_log[(rd0 + 1) % 2], eladdr);
        chk(n_st - st0 == ((enrd == 2 && enew != eold) ? 1 : 0), {tag, " R8 store count"},
            n_st - st0, (enrd == 2 && enew != eold) ? 1 : 0);
        if (enrd == 2)
            chk(mem[eladdr[13:2]] == enew, {tag, " R8 leaf word after walk"}, mem[eladdr[13:2]], enew);
        @(negedge clk);
        chk(rsp_valid == 1'b0 && req_ready == 1'b1, {tag, " R10 pulse then idle"},
            {30'b0, rsp_valid, req_ready}, 32'h1);
    endtask

    function automatic logic [31:0] mkva(input int ri, input int li, input int off);
        return {ri[9:0], li[9:0], off[11:0]};
    endfunction

    // Place a root entry and a leaf entry for a directed case.
    task automatic place(input int rframe, input int ri, input logic [31:0] rent,
                         input int li, input logic [31:0] lent);
        mem[rframe * 1024 + ri] = rent;
        if (rent[0]) mem[rent[13:12] * 1024 + li] = lent;
    endtask

    initial begin
        logic [31:0] w;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4096; i++) begin
            w = $urandom;
            if (((i >> 10) % 2) == 0)
                mem[i] = {18'b0, (($urandom % 2) != 0) ? 2'b01 : 2'b11, w[11:1], ($urandom % 8) != 0};
            else
                mem[i] = {w[31:1], ($urandom % 8) != 0};
        end

        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req == 1'b0, "R1 state in reset",
            {29'b0, req_ready, rsp_valid, mem_req}, 32'h4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req == 1'b0, "R1 state after reset",
            {29'b0, req_ready, rsp_valid, mem_req}, 32'h4);

        // R4: absent root entry.
        place(0, 5, 32'h0000_1000, 0, 0);
        do_walk(mkva(5, 7, 12'h123), 2'b00, 32'h0, 1'b0, "R4 absent root");
        // R5: absent leaf entry.
        place(0, 6, 32'h0000_1001, 8, 32'hABCDE_00E);
        do_walk(mkva(6, 8, 12'h456), 2'b00, 32'h0, 1'b0, "R5 absent leaf");
        // R6: write to read-only page with clear referenced bit.
        place(0, 9, 32'h0000_3001, 10, 32'h12345_003);
        do_walk(mkva(9, 10, 12'h001), 2'b01, 32'h0, 1'b0, "R6 write to read-only");
        // R6: execute on a non-executable page.
        place(0, 11, 32'h0000_1001, 12, 32'h22222_007);
        do_walk(mkva(11, 12, 12'hFFF), 2'b10, 32'h0, 1'b0, "R6 exec refused");
        // R6: access code 11 on a fully enabled page.
        place(0, 13, 32'h0000_3001, 14, 32'h33333_00F);
        do_walk(mkva(13, 14, 12'h800), 2'b11, 32'h0, 1'b0, "R6 code 11 refused");
        // R8: write success sets both status bits.
        place(0, 15, 32'h0000_1001, 16, 32'h44444_007);
        do_walk(mkva(15, 16, 12'hABC), 2'b01, 32'h0, 1'b0, "R8 write sets ref and mod");
        // R8: read with referenced already set makes no store.
        place(0, 17, 32'h0000_3001, 18, 32'h55555_013);
        do_walk(mkva(17, 18, 12'h010), 2'b00, 32'h0, 1'b0, "R8 read no store");
        // R9: cache-disable flag passes through.
        place(0, 19, 32'h0000_1001, 20, 32'h66666_053);
        do_walk(mkva(19, 20, 12'h3A0), 2'b00, 32'h0, 1'b0, "R9 nocache");
        // R2: alternate root table at frame 2.
        place(2, 21, 32'h0000_3001, 22, 32'h77777_00B);
        do_walk(mkva(21, 22, 12'h044), 2'b10, 32'h0000_2000, 1'b0, "R2 root switch");
        // R2: base change during a walk is ignored.
        place(0, 23, 32'h0000_1001, 24, 32'h88888_003);
        place(2, 23, 32'h0000_0000, 0, 0);
        do_walk(mkva(23, 24, 12'h0C0), 2'b00, 32'h0, 1'b1, "R2 base change mid walk");
        // R11 and R3 over random walks with random entries.
        for (int k = 0; k < 250; k++) begin
            do_walk($urandom, 2'($urandom), (($urandom % 2) != 0) ? 32'h0000_2000 : 32'h0,
                    1'(($urandom % 4) == 0), "R3 R11 random walk");
        end

        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule